// File: doc/BRIEF.md
# Compressed Instruction Length and Legality Gate

This block sits in the fetch stage of a RISC-V style core. Each cycle the fetch path hands it a full 32-bit word read at the current PC, whether or not the instruction there is 16 bits long. It also receives the PC and the machine ISA configuration register. The two lowest bits of the word set the instruction length. The block sends the whole word to the standard decoder and the low half to the compressed decoder. One cycle later it reports one of three outcomes: a sequential advance with the next PC, an illegal-instruction trap request, or a decode failure.

The ISA configuration register carries a two-bit XLEN code in its top two bits and one bit per extension letter in bits 25 down to 0, with A at bit 0. Only the compressed-extension bit matters here; it sits at bit 2. When that bit is clear, every 16-bit instruction becomes an illegal-instruction trap. The trap value is the fetched word, zero-extended. The block also flags the compressed NOP class, so that a later stage can retire such an instruction with no other effect.

Top module: `rvc_len_gate`

## Requirements
- R1: When `fetch_word[1:0]` is 2'b11 the instruction is 32 bits long and the registered `is_cmp` is 0. Any other value of those bits makes it 16 bits long, with `is_cmp` 1.
- R2: `std_word` always equals `fetch_word` and `cmp_half` always equals `fetch_word[15:0]`, in the same cycle, with no register between.
- R3: When the instruction advances, `adv` is 1 and `next_pc` is the sampled PC plus 4 for a 32-bit instruction or plus 2 for a 16-bit instruction, modulo 2^XLEN.
- R4: A 16-bit instruction sampled while `isa_cfg[2]` is 0 raises `trap` and does not advance. No other bit of `isa_cfg` changes any outcome, and 32-bit instructions never trap on this condition.
- R5: With `trap`, `trap_val` is the sampled `fetch_word` zero-extended to XLEN bits.
- R6: When no trap is raised and `dec_hit` is 0, `dec_fail` is 1 and `adv` is 0. The compressed-disabled trap takes priority over a decode failure.
- R7: `cnop` is 1 when the sampled word is 16 bits long and has bits [15:13]=000, [11:7]=00000 and [1:0]=01, for any value of bit 12 and bits [6:2]. Otherwise it is 0.
- R8: All outcome outputs are registered. `out_vld`, `adv`, `trap`, `dec_fail`, `is_cmp` and `cnop` reflect the word sampled with `fetch_vld` at the previous rising edge, and all are 0 in a cycle that follows no fetch.
- R9: A synchronous active-high `rst` clears `out_vld`, `adv`, `trap`, `dec_fail`, `is_cmp`, `cnop`, `next_pc` and `trap_val`.
- R10: At most one of `adv`, `trap` and `dec_fail` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_vld | input | 1 | A fetched word is present this cycle |
| fetch_word | input | 32 | Word read at the PC |
| pc | input | XLEN | Address of the fetched word |
| isa_cfg | input | XLEN | ISA configuration register; bit 2 enables compressed instructions |
| dec_hit | input | 1 | The selected decoder recognised the instruction |
| std_word | output | 32 | Word for the standard decoder |
| cmp_half | output | 16 | Low half for the compressed decoder |
| out_vld | output | 1 | Registered outcome is valid |
| is_cmp | output | 1 | Sampled instruction was 16 bits long |
| adv | output | 1 | Sequential advance |
| next_pc | output | XLEN | Next PC on advance |
| trap | output | 1 | Illegal-instruction trap request |
| trap_val | output | XLEN | Zero-extended faulting word |
| dec_fail | output | 1 | Decoder reported no match |
| cnop | output | 1 | Compressed NOP class |

## Verification
The bench builds the block with its defaults: XLEN of 64 and the enable bit at position 2. That width lets it set every non-enable bit of the configuration register, including the XLEN code, and confirm they have no effect. It also lets the PC run up to its top value, so the plus-2 wrap to zero is within reach. A single word of all zeros, sampled with compressed instructions off and no decoder match, reaches the case where the trap and a decode failure compete.

// File: rtl/rvc_len_gate.sv
module rvc_len_gate #(
  parameter int XLEN    = 64,
  parameter int ILEN    = 32,
  parameter int CEN_BIT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_vld,
  input  logic [ILEN-1:0] fetch_word,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] isa_cfg,
  input  logic            dec_hit,
  output logic [ILEN-1:0] std_word,
  output logic [ILEN/2-1:0] cmp_half,
  output logic            out_vld,
  output logic            is_cmp,
  output logic            adv,
  output logic [XLEN-1:0] next_pc,
  output logic            trap,
  output logic [XLEN-1:0] trap_val,
  output logic            dec_fail,
  output logic            cnop
);
  localparam int HALF = ILEN / 2;

  logic            short_i;
  logic            c_off;
  logic            trap_d;
  logic            nop_d;
  logic [XLEN-1:0] step;

  assign std_word = fetch_word;
  assign cmp_half = fetch_word[HALF-1:0];

  assign short_i = fetch_word[1:0] != 2'b11;
  assign c_off   = !isa_cfg[CEN_BIT];
  assign trap_d  = short_i && c_off;
  assign nop_d   = fetch_word[1:0] == 2'b01 && fetch_word[15:13] == 3'b000 &&
                   fetch_word[11:7] == 5'b00000;
  assign step    = short_i ? XLEN'(2) : XLEN'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      is_cmp   <= 1'b0;
      adv      <= 1'b0;
      trap     <= 1'b0;
      dec_fail <= 1'b0;
      cnop     <= 1'b0;
      next_pc  <= '0;
      trap_val <= '0;
    end else begin
      out_vld  <= fetch_vld;
      is_cmp   <= fetch_vld && short_i;
      cnop     <= fetch_vld && nop_d;
      trap     <= fetch_vld && trap_d;
      dec_fail <= fetch_vld && !trap_d && !dec_hit;
      adv      <= fetch_vld && !trap_d && dec_hit;
      if (fetch_vld) begin
        next_pc  <= pc + step;
        trap_val <= XLEN'(fetch_word);
      end
    end
  end
endmodule

module rvc_len_gate_chk #(
  parameter int XLEN = 64,
  parameter int ILEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_vld,
  input logic [ILEN-1:0] fetch_word,
  input logic [XLEN-1:0] pc,
  input logic            out_vld,
  input logic            is_cmp,
  input logic            adv,
  input logic [XLEN-1:0] next_pc,
  input logic            trap,
  input logic [XLEN-1:0] trap_val,
  input logic            dec_fail
);
  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({adv, trap, dec_fail}));

  // R8
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_vld |=> out_vld);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_vld |=> !adv && !trap && !dec_fail && !out_vld);

  // R4
  trap_short_chk: assert property (@(posedge clk) disable iff (rst)
    trap |-> is_cmp && out_vld);

  // R5
  trap_val_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_vld |=> trap_val == XLEN'($past(fetch_word)));

  // R3
  next_pc_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_vld |=> next_pc == $past(pc) + (is_cmp ? XLEN'(2) : XLEN'(4)));
endmodule

bind rvc_len_gate rvc_len_gate_chk #(.XLEN(XLEN), .ILEN(ILEN)) u_chk (
  .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_word(fetch_word),
  .pc(pc), .out_vld(out_vld), .is_cmp(is_cmp), .adv(adv), .next_pc(next_pc),
  .trap(trap), .trap_val(trap_val), .dec_fail(dec_fail)
);

// File: tb/rvc_len_gate_bench.sv
module rvc_len_gate_bench;
  localparam int XLEN = 64;
  localparam int NV   = 10;
  localparam logic [XLEN-1:0] CFG_ON  = 64'h8000_0000_0014_1105;
  localparam logic [XLEN-1:0] CFG_OFF = 64'hFFFF_FFFF_FFFF_FFFB;

  localparam logic [31:0] VW [NV] = '{32'h0000_0013, 32'h0000_0001, 32'hABCD_4505,
    32'h1234_0001, 32'h0000_0013, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0000,
    32'h0000_107D, 32'h0000_0081};
  localparam logic VC [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic VH [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_vld = 1'b0;
  logic [31:0] fetch_word = '0;
  logic [XLEN-1:0] pc = '0;
  logic [XLEN-1:0] isa_cfg = CFG_ON;
  logic dec_hit = 1'b0;
  logic [31:0] std_word;
  logic [15:0] cmp_half;
  logic out_vld, is_cmp, adv, trap, dec_fail, cnop;
  logic [XLEN-1:0] next_pc, trap_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rvc_len_gate u_rvc_len_gate (
    .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_word(fetch_word),
    .pc(pc), .isa_cfg(isa_cfg), .dec_hit(dec_hit), .std_word(std_word),
    .cmp_half(cmp_half), .out_vld(out_vld), .is_cmp(is_cmp), .adv(adv),
    .next_pc(next_pc), .trap(trap), .trap_val(trap_val), .dec_fail(dec_fail),
    .cnop(cnop)
  );

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic [XLEN-1:0] p,
                      input logic [XLEN-1:0] cfg, input logic hit);
    @(negedge clk);
    fetch_vld  = 1'b1;
    fetch_word = w;
    pc         = p;
    isa_cfg    = cfg;
    dec_hit    = hit;
    #1;
    check("R2 std_word", XLEN'(std_word), XLEN'(w));
    check("R2 cmp_half", XLEN'(cmp_half), XLEN'(w[15:0]));
    @(negedge clk);
    fetch_vld = 1'b0;
  endtask

  task automatic expect_out(input logic [31:0] w, input logic [XLEN-1:0] p,
                            input logic cen, input logic hit);
    logic sh, et, ef, ea, en;
    sh = w[1:0] != 2'b11;
    et = sh && !cen;
    ef = !et && !hit;
    ea = !et && hit;
    en = w[1:0] == 2'b01 && w[15:13] == 3'b000 && w[11:7] == 5'b00000;
    check("R8 out_vld", XLEN'(out_vld), 1);
    check("R1 is_cmp", XLEN'(is_cmp), XLEN'(sh));
    check("R4 trap", XLEN'(trap), XLEN'(et));
    check("R6 dec_fail", XLEN'(dec_fail), XLEN'(ef));
    check("R3 adv", XLEN'(adv), XLEN'(ea));
    check("R7 cnop", XLEN'(cnop), XLEN'(en));
    if (ea) check("R3 next_pc", next_pc, p + (sh ? 64'd2 : 64'd4));
    if (et) check("R5 trap_val", trap_val, {32'h0, w});
    check("R10 one outcome", XLEN'(32'(adv) + 32'(trap) + 32'(dec_fail)), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset out_vld", XLEN'(out_vld), 0);
    check("R9 reset flags", XLEN'({adv, trap, dec_fail, is_cmp, cnop}), 0);
    check("R9 reset next_pc", next_pc, 0);
    check("R9 reset trap_val", trap_val, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [XLEN-1:0] p;
      p = 64'h8000_0000 + 64'(i * 6);
      send(VW[i], p, VC[i] ? CFG_ON : CFG_OFF, VH[i]);
      expect_out(VW[i], p, VC[i], VH[i]);
    end

    // R8 idle cycle after a fetch
    @(negedge clk);
    check("R8 idle out_vld", XLEN'(out_vld), 0);
    check("R8 idle flags", XLEN'({adv, trap, dec_fail, is_cmp, cnop}), 0);

    // R3 wrap of PC at the top of the address space
    send(32'h0000_0001, 64'hFFFF_FFFF_FFFF_FFFE, CFG_ON, 1'b1);
    check("R3 wrap next_pc", next_pc, 64'h0);
    send(32'h0000_0013, 64'hFFFF_FFFF_FFFF_FFFE, CFG_ON, 1'b1);
    check("R3 wrap next_pc 32-bit", next_pc, 64'h2);

    // R4 only bit 2 matters: enable bit alone set
    send(32'h0000_4501, 64'h100, 64'h4, 1'b1);
    check("R4 bit2 only enables", XLEN'({adv, trap}), 2'b10);
    send(32'h0000_4501, 64'h100, 64'h0, 1'b1);
    check("R4 all clear traps", XLEN'({adv, trap}), 2'b01);

    // R9 reset in the middle of activity
    @(negedge clk);
    fetch_vld = 1'b1; fetch_word = 32'h0000_0001; isa_cfg = CFG_OFF; dec_hit = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid reset clears", XLEN'({out_vld, adv, trap, dec_fail, is_cmp, cnop}), 0);
    check("R9 mid reset trap_val", trap_val, 0);
    fetch_vld = 1'b0; rst = 1'b0;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule